// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block runs one complete configuration session on a passive-serial port of a programmable target device. A host pulses `start`. The block then holds the active-low configuration request low for a fixed 40 µs and releases it. It waits for the target's active-low status line to read high, and gives up after a programmable number of cycles if that never happens. It then takes bitstream bytes from the host over a valid/ready handshake. Each byte goes out least significant bit first on a single data line, and every bit is marked by one pulse of a configuration clock that rests low.

When the host raises `finish`, the block waits for any byte still being shifted to complete. It then samples the target's status and done lines and latches a verdict, which stays on the result outputs until the next session starts. A strap input tells the block that no target is fitted. With it set, the status wait is skipped and the verdict is always success.

The 40 µs hold is converted to clock cycles from a clock-frequency parameter. Each high and each low phase of the configuration clock lasts a runtime-programmable half period. The status inputs are assumed to be already synchronous to `clk`.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, `cfg_req_n` is 1 and `cfg_clk`, `cfg_dat`, `byte_ready`, `res_done` and `res_err` are 0, with `res_code` 0.
- R2: A start accepted while idle or while showing a result drives `cfg_req_n`, `cfg_clk` and `cfg_dat` low and clears the result outputs. `cfg_req_n` stays low for exactly HOLD_US × CLK_HZ / 1e6 cycles and then returns high.
- R3: After the request is released, no byte is accepted while `tgt_stat_n` is low. `byte_ready` rises on the cycle after `tgt_stat_n` is seen high. `byte_ready` is high only while the session is in its shifting phase, the serializer is idle and `finish` is low.
- R4: If `tgt_stat_n` stays low for `status_timeout`+1 cycles after the release, the session ends with `res_done`=1, `res_err`=1 and `res_code`=3 (timeout).
- R5: Each accepted byte appears on `cfg_dat`, sampled at the rising edges of `cfg_clk`, bit 0 first and bit 7 last.
- R6: `cfg_dat` is set at least one half period before each rising edge of `cfg_clk` and stays stable while `cfg_clk` is high. Within a byte, every high phase and every low phase lasts max(`half_period`,1) cycles.
- R7: `cfg_clk` is low whenever `byte_ready` is high and outside the shifting phase, so it rests low between bytes.
- R8: If `tgt_stat_n` is low when the finish is taken, the result is `res_err`=1 with `res_code`=1 (status failure).
- R9: If `tgt_stat_n` is high and `tgt_done` is low when the finish is taken, the result is `res_err`=1 with `res_code`=2 (incomplete).
- R10: If `tgt_stat_n` and `tgt_done` are both high when the finish is taken, the result is `res_err`=0 with `res_code`=0 (success).
- R11: With `tgt_absent`=1, `byte_ready` rises one cycle after the request is released, whatever `tgt_stat_n` is, and the finish reports success.
- R12: The result outputs hold their values until the next start. A start raised during the hold, wait or shifting phase is ignored.
- R13: A finish raised while a byte is still being shifted takes effect only after that byte's eighth clock pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new configuration session |
| finish | input | 1 | Request the completion check |
| tgt_absent | input | 1 | Strap: no target fitted |
| half_period | input | HP_W | Configuration clock half period in cycles (0 behaves as 1) |
| status_timeout | input | TO_W | Status wait limit; expiry after this value + 1 cycles |
| byte_valid | input | 1 | Host byte is valid |
| byte_data | input | 8 | Host byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| cfg_clk | output | 1 | Configuration clock |
| cfg_dat | output | 1 | Serial configuration data |
| tgt_stat_n | input | 1 | Target status, active low (low = error or busy) |
| tgt_done | input | 1 | Target reports configuration complete |
| res_done | output | 1 | Session result valid |
| res_err | output | 1 | Session failed |
| res_code | output | 2 | 0 success, 1 status failure, 2 incomplete, 3 timeout |

## Verification
The hardest case to reach from the ports is a finish that arrives while a byte is half shifted out. In that case the handshake must be held off and the verdict delayed until the serializer has drained. The bench sets up this case by raising `finish` directly after each final byte is accepted, and it keeps `finish` high until a result appears. A monitor rebuilds every byte from the clock edges and measures every phase width. The bench then checks that the verdict arrives only after all expected bits were seen. A second hard case is a start pulse in the middle of a byte. The bench drives one with a long half period and then checks that the request line stays released and that the byte stream still arrives complete.

// File: rtl/ps_cfg_pkg.sv
// Shared types and helpers for the passive-serial configuration loader.
// Assumes: integer clock frequency in Hz, at least 1 MHz for exact hold time.
package ps_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAIT,
        ST_SHIFT,
        ST_RESULT
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK          = 2'd0,
        RES_STATUS_FAIL = 2'd1,
        RES_INCOMPLETE  = 2'd2,
        RES_TIMEOUT     = 2'd3
    } res_code_t;

    // Convert a microsecond hold into clock cycles, never below one cycle.
    function automatic int unsigned hold_cycles(input int unsigned clk_hz,
                                                input int unsigned us);
        int unsigned c;
        c = (clk_hz / 32'd1000000) * us;
        return (c == 0) ? 32'd1 : c;
    endfunction

endpackage

// File: rtl/ps_cfg_shifter.sv
// Byte serializer for the configuration port.
// Loads one byte, presents bit 0 on the data line, then per bit runs one low
// phase followed by one high phase of the configuration clock, each lasting
// max(half_period,1) cycles. Data changes only at the start of a low phase.
// Assumes: load is only raised while busy is low; clr aborts any transfer.
module ps_cfg_shifter #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [HP_W-1:0] half_period,
    input  logic            load,
    input  logic [7:0]      load_data,
    output logic            busy,
    output logic            sclk,
    output logic            sdat
);
    localparam int BIT_W = 3;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(7);

    logic [7:0]       sreg;
    logic [BIT_W-1:0] bidx;
    logic [HP_W-1:0]  phase_cnt;
    logic [HP_W-1:0]  phase_last;

    // Last count value of a phase; a zero half period behaves as one cycle.
    always_comb begin
        phase_last = (half_period == '0) ? '0 : half_period - 1'b1;
    end

    // Phase timing, bit stepping and data presentation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sreg      <= '0;
            bidx      <= '0;
            phase_cnt <= '0;
            busy      <= 1'b0;
            sclk      <= 1'b0;
            sdat      <= 1'b0;
        end else if (load) begin
            sreg      <= load_data;
            sdat      <= load_data[0];
            bidx      <= '0;
            phase_cnt <= '0;
            busy      <= 1'b1;
            sclk      <= 1'b0;
        end else if (busy) begin
            if (phase_cnt == phase_last) begin
                phase_cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bidx == LAST_BIT) begin
                        busy <= 1'b0;
                    end else begin
                        bidx <= bidx + 1'b1;
                        sreg <= sreg >> 1;
                        sdat <= sreg[1];
                    end
                end
            end else begin
                phase_cnt <= phase_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ps_cfg_seq.sv
// Session sequencer: request hold, status wait with timeout, shifting phase
// and completion verdict. Owns the active-low request line and the result.
// Assumes: tgt_stat_n and tgt_done are synchronous to clk.
module ps_cfg_seq
    import ps_cfg_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 40,
    parameter int          TO_W     = 24,
    parameter int          CNT_W    = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            finish,
    input  logic            tgt_absent,
    input  logic [TO_W-1:0] status_timeout,
    input  logic            tgt_stat_n,
    input  logic            tgt_done,
    input  logic            shift_busy,
    output logic            shift_clr,
    output logic            in_shift,
    output logic            cfg_req_n,
    output logic            res_done,
    output logic            res_err,
    output logic [1:0]      res_code
);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             start_ok;
    logic             finish_ok;
    res_code_t        verdict;

    // Start is honoured only outside a running session.
    always_comb begin
        start_ok  = start && (state == ST_IDLE || state == ST_RESULT);
        finish_ok = finish && (state == ST_SHIFT) && !shift_busy;
        shift_clr = start_ok;
        in_shift  = (state == ST_SHIFT);
    end

    // Completion verdict from the target status lines.
    always_comb begin
        if (tgt_absent)       verdict = RES_OK;
        else if (!tgt_stat_n) verdict = RES_STATUS_FAIL;
        else if (!tgt_done)   verdict = RES_INCOMPLETE;
        else                  verdict = RES_OK;
    end

    // Session state machine, shared phase counter and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cfg_req_n <= 1'b1;
            res_done  <= 1'b0;
            res_err   <= 1'b0;
            res_code  <= RES_OK;
        end else begin
            case (state)
                ST_IDLE, ST_RESULT: begin
                    if (start_ok) begin
                        state     <= ST_HOLD;
                        cnt       <= '0;
                        cfg_req_n <= 1'b0;
                        res_done  <= 1'b0;
                        res_err   <= 1'b0;
                        res_code  <= RES_OK;
                    end
                end
                ST_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        cfg_req_n <= 1'b1;
                        cnt       <= '0;
                        state     <= ST_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (tgt_absent || tgt_stat_n) begin
                        state <= ST_SHIFT;
                    end else if (cnt == CNT_W'(status_timeout)) begin
                        state    <= ST_RESULT;
                        res_done <= 1'b1;
                        res_err  <= 1'b1;
                        res_code <= RES_TIMEOUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (finish_ok) begin
                        state    <= ST_RESULT;
                        res_done <= 1'b1;
                        res_err  <= (verdict != RES_OK);
                        res_code <= verdict;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ps_cfg_loader.sv
// Top of the passive-serial configuration loader.
// Ties the session sequencer to the byte serializer and gates the host
// handshake so a byte is only taken while the serializer is idle.
// Assumes: CLK_HZ is the frequency of clk; status inputs are synchronous.
module ps_cfg_loader #(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned HOLD_US = 40,
    parameter int          HP_W    = 8,
    parameter int          TO_W    = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            finish,
    input  logic            tgt_absent,
    input  logic [HP_W-1:0] half_period,
    input  logic [TO_W-1:0] status_timeout,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    output logic            byte_ready,
    output logic            cfg_req_n,
    output logic            cfg_clk,
    output logic            cfg_dat,
    input  logic            tgt_stat_n,
    input  logic            tgt_done,
    output logic            res_done,
    output logic            res_err,
    output logic [1:0]      res_code
);
    localparam int unsigned HOLD_CYC = ps_cfg_pkg::hold_cycles(CLK_HZ, HOLD_US);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam int CNT_W  = (HOLD_W > TO_W) ? HOLD_W : TO_W;

    logic shift_busy;
    logic shift_clr;
    logic in_shift;
    logic load;

    // Host handshake: ready only with an idle serializer and no finish pending.
    always_comb begin
        byte_ready = in_shift && !shift_busy && !finish;
        load       = byte_valid && byte_ready;
    end

    ps_cfg_seq #(
        .HOLD_CYC (HOLD_CYC),
        .TO_W     (TO_W),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .finish         (finish),
        .tgt_absent     (tgt_absent),
        .status_timeout (status_timeout),
        .tgt_stat_n     (tgt_stat_n),
        .tgt_done       (tgt_done),
        .shift_busy     (shift_busy),
        .shift_clr      (shift_clr),
        .in_shift       (in_shift),
        .cfg_req_n      (cfg_req_n),
        .res_done       (res_done),
        .res_err        (res_err),
        .res_code       (res_code)
    );

    ps_cfg_shifter #(
        .HP_W (HP_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (shift_clr),
        .half_period (half_period),
        .load        (load),
        .load_data   (byte_data),
        .busy        (shift_busy),
        .sclk        (cfg_clk),
        .sdat        (cfg_dat)
    );

endmodule

// File: rtl/ps_cfg_loader_chk.sv
// Port-level property checker for ps_cfg_loader, attached by bind.
// Assumes: rst_n is held low for at least one clock at the start of time.
module ps_cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       byte_valid,
    input logic       byte_ready,
    input logic       cfg_req_n,
    input logic       cfg_clk,
    input logic       cfg_dat,
    input logic       res_done,
    input logic       res_err,
    input logic [1:0] res_code
);

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_n |-> (!cfg_clk && !byte_ready)); // R2

    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (!cfg_clk && cfg_req_n)); // R7

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk && $past(cfg_clk)) |-> (cfg_dat == $past(cfg_dat))); // R6

    AST_LOAD_BEFORE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> !cfg_clk); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !start) |=> (res_done && $stable(res_code) && $stable(res_err))); // R12

    AST_NO_STALE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> (!res_err && res_code == 2'd0)); // R2

endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (.*);

// File: tb/ps_cfg_loader_bench.sv
module ps_cfg_loader_bench;
    localparam int HP_W = 4;
    localparam int TO_W = 8;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, finish = 1'b0, tgt_absent = 1'b0;
    logic [HP_W-1:0] half_period = 4'd1;
    logic [TO_W-1:0] status_timeout = 8'd200;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic byte_ready, cfg_req_n, cfg_clk, cfg_dat;
    logic tgt_stat_n = 1'b0, tgt_done = 1'b0;
    logic res_done, res_err;
    logic [1:0] res_code;

    int n_checks = 0;
    int n_fail = 0;
    int mon_hp = 1;
    logic [7:0] exp_q [0:511];
    int n_sent = 0;
    int n_recv = 0;
    int bitn = 0;
    logic [7:0] rx = 8'h00;
    logic pclk = 1'b0, pdat = 1'b0;
    int hirun = 0, lowrun = 0;

    always #4 clk = ~clk;

    ps_cfg_loader #(.CLK_HZ(1_000_000), .HOLD_US(40), .HP_W(HP_W), .TO_W(TO_W)) u_ps_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .finish(finish), .tgt_absent(tgt_absent),
        .half_period(half_period), .status_timeout(status_timeout),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .cfg_req_n(cfg_req_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat),
        .tgt_stat_n(tgt_stat_n), .tgt_done(tgt_done),
        .res_done(res_done), .res_err(res_err), .res_code(res_code));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: rebuild bytes from clock rises, measure phase widths.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_clk && !pclk) begin
                if (bitn > 0) chk(lowrun == mon_hp, "R6", "low phase width", lowrun, mon_hp);
                rx = {cfg_dat, rx[7:1]};
                bitn++;
                hirun = 1;
                if (bitn == 8) begin
                    chk(rx == exp_q[n_recv], "R5", "byte LSB first", rx, exp_q[n_recv]);
                    n_recv++;
                    bitn = 0;
                end
            end else if (cfg_clk) begin
                hirun++;
                chk(cfg_dat == pdat, "R6", "data stable while high", cfg_dat, pdat);
            end else if (pclk) begin
                chk(hirun == mon_hp, "R6", "high phase width", hirun, mon_hp);
                lowrun = 1;
            end else begin
                lowrun++;
            end
            pclk = cfg_clk;
            pdat = cfg_dat;
        end
    end

    // Pulse start and measure the request hold; returns on the release sample.
    task automatic start_session();
        int n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!cfg_clk && !cfg_dat && !res_done, "R2", "lines low, result cleared",
            {cfg_clk, cfg_dat, res_done}, 0);
        n = 0;
        while (!cfg_req_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == HOLD, "R2", "request hold cycles", n, HOLD);
    endtask

    task automatic send_byte(input logic [7:0] b);
        int g = 0;
        while (!byte_ready && g < 1000) begin g++; @(negedge clk); end
        chk(!cfg_clk, "R7", "clock low while ready", cfg_clk, 0);
        exp_q[n_sent] = b;
        n_sent++;
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk) byte_valid = 1'b0;
    endtask

    task automatic do_finish(input int code, input string req);
        int g = 0;
        finish = 1'b1;
        @(negedge clk);
        while (!res_done && g < 1000) begin
            chk(!byte_ready, "R3", "no ready while finishing", byte_ready, 0);
            g++;
            @(negedge clk);
        end
        finish = 1'b0;
        chk(n_recv == n_sent && bitn == 0, "R13", "verdict after last bit", n_recv, n_sent);
        chk(res_code == code, req, "result code", res_code, code);
        chk(res_err == (code != 0), req, "result error flag", res_err, code != 0);
        chk(!cfg_clk, "R7", "clock idle after session", cfg_clk, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(cfg_req_n && !cfg_clk && !cfg_dat && !byte_ready && !res_done && !res_err
            && res_code == 0, "R1", "reset state",
            {cfg_req_n, cfg_clk, cfg_dat, byte_ready, res_done, res_err}, 32);
        rst_n = 1'b1;
        @(negedge clk);

        // Session A: status held low, then all 256 byte values, half period 1.
        mon_hp = 1; half_period = 4'd1; tgt_done = 1'b1;
        start_session();
        for (int i = 0; i < 10; i++) begin
            chk(!byte_ready, "R3", "no ready while status low", byte_ready, 0);
            @(negedge clk);
        end
        tgt_stat_n = 1'b1;
        @(negedge clk);
        chk(byte_ready, "R3", "ready one cycle after status high", byte_ready, 1);
        for (int b = 0; b < 256; b++) send_byte(8'(b));
        do_finish(0, "R10");
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk(res_done && res_code == 0, "R12", "result held", res_done, 1);

        // Session B: half period 3, ignored mid-byte start, incomplete verdict.
        mon_hp = 3; half_period = 4'd3; tgt_done = 1'b0; tgt_stat_n = 1'b1;
        start_session();
        send_byte(8'hA5);
        send_byte(8'h3C);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(cfg_req_n, "R12", "start ignored while shifting", cfg_req_n, 1);
            @(negedge clk);
        end
        send_byte(8'h81);
        send_byte(8'h7E);
        do_finish(2, "R9");

        // Session C: zero half period behaves as one; status failure.
        mon_hp = 1; half_period = 4'd0; tgt_done = 1'b1;
        start_session();
        send_byte(8'h01);
        send_byte(8'h80);
        send_byte(8'hF0);
        tgt_stat_n = 1'b0;
        do_finish(1, "R8");

        // Session D: status never rises, timeout of 5.
        status_timeout = 8'd5;
        start_session();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!res_done && !byte_ready, "R4", "no expiry yet", res_done, 0);
        end
        @(negedge clk);
        chk(res_done && res_err && res_code == 3, "R4", "timeout verdict", res_code, 3);

        // Session E: target absent, status low and done low.
        tgt_absent = 1'b1; tgt_done = 1'b0; status_timeout = 8'd200;
        start_session();
        @(negedge clk);
        chk(byte_ready, "R11", "wait skipped", byte_ready, 1);
        send_byte(8'h5A);
        send_byte(8'hC3);
        do_finish(0, "R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule